// File: doc/BRIEF.md
# SDRAM Burst Sequencer With Programmable Mode Word

This block is the device-side controller for the data phase of a synchronous DRAM. A command decoder in front of it presents one command per clock: no-operation, mode load, read or write. A mode load captures a 10-bit word from the address bus. That word sets the burst length, the burst ordering, the read latency and whether writes burst or touch a single location. Every later read or write uses those settings to produce one column address per clock. The block takes the starting column from the address bus.

For reads, the column of each beat comes out together with a data-valid strobe, 2 or 3 cycles after the command. An output-drive enable rises one cycle ahead of the first valid beat. For writes, each beat's column, a write strobe and the data word captured on the same edge appear right after that edge. Mode words that use reserved encodings raise a level error flag, and the engine then refuses reads and writes. A mode load that arrives while a burst is still in flight is dropped and reported by a one-cycle pulse.

Top module: `sdr_burst_ctrl`

## Requirements
- R1: After synchronous reset all strobes, the drive enable and both flags are low, and the mode behaves as burst length 1, sequential order, latency 2, bursting writes.
- R2: The burst-length field addr_i[2:0] gives 1, 2, 4 or 8 beats for codes 000, 001, 010, 011. Each beat is issued on consecutive clocks.
- R3: With addr_i[3]=0 (sequential), beat i of a burst of length L has column base + ((start mod L) + i) mod L, where base is start rounded down to a multiple of L.
- R4: With addr_i[3]=1 (interleaved), beat i has column base + ((start mod L) XOR i).
- R5: The latency field addr_i[6:4] accepts 010 (2) and 011 (3). For a READ (cmd_i=10) taken at edge n with latency m, rd_valid_o and rd_col_o for beat i appear after edge n+m+i.
- R6: dq_oe_o goes high after edge n+m-1, stays high through every valid beat, and drops after the edge that follows the final beat.
- R7: A READ or WRITE taken while beats remain abandons the rest of the earlier burst and starts the new one on the next beat slot. A READ taken on the edge right after the last beat issue continues the valid stream and the drive enable without a gap.
- R8: A WRITE (cmd_i=11) taken at edge n shows wr_o, wr_col_o and the wdata_i sampled at edge n+i after edge n+i for beat i. With addr_i[9]=0 a write bursts the programmed length. With addr_i[9]=1 a write is a single beat while reads still burst.
- R9: A loaded word with addr_i[8:7] nonzero, a burst code of 1xx, or a latency code other than 010 or 011 sets mode_err_o after the load edge. While it is set, READ and WRITE produce no strobes and no drive. Loading a legal word clears it.
- R10: A LOAD MODE (cmd_i=01) is dropped, with load_rej_o high for one cycle after that edge, when it arrives on edges n+1 through n+L of a write taken at edge n, or on edges n+1 through n+m+L-1 of a read. One edge later it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 NOP, 01 load mode, 10 read, 11 write |
| addr_i | input | ADDR_W | Mode word on load, starting column in the low COL_W bits on read or write |
| wdata_i | input | DATA_W | Write data, sampled every clock |
| rd_valid_o | output | 1 | Read beat valid |
| rd_col_o | output | COL_W | Column of the valid read beat |
| dq_oe_o | output | 1 | Data output-drive enable |
| wr_o | output | 1 | Write beat strobe |
| wr_col_o | output | COL_W | Column of the write beat |
| wr_data_o | output | DATA_W | Data of the write beat |
| mode_err_o | output | 1 | Mode register holds a reserved encoding |
| load_rej_o | output | 1 | One-cycle pulse: a mode load was dropped |

## Verification
The hardest situation to reach is the exact edge at which a mode load stops being rejected. That edge depends on the command type, the burst length and the latency, and it includes the stale last latency stage. The bench places the load on the final rejected edge and then on the first accepted edge, for both a read and a write. It then runs a full burst to show through the ports whether the old or the new setting is in force. Seamless and truncating command pairs are placed on computed edges in the same way, so that the new burst lands exactly on the slot after the last issued beat.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  localparam int MODE_W  = 10;
  localparam int MAX_LAT = 3;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_LOAD  = 2'b01,
    CMD_READ  = 2'b10,
    CMD_WRITE = 2'b11
  } sdr_cmd_e;

  // field layout: [9] single-beat writes, [8:7] operating mode,
  // [6:4] read latency, [3] interleaved order, [2:0] burst length
  typedef struct packed {
    logic       wr_single;
    logic [1:0] op;
    logic [2:0] lat;
    logic       ilv;
    logic [2:0] bl;
  } mode_word_t;

  localparam mode_word_t MODE_RESET = '{
    wr_single: 1'b0, op: 2'b00, lat: 3'd2, ilv: 1'b0, bl: 3'd0
  };

  function automatic logic mode_legal(input mode_word_t m);
    return (m.op == 2'b00) && !m.bl[2] && ((m.lat == 3'd2) || (m.lat == 3'd3));
  endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  input  logic              active_i,
  output logic [1:0]        bl_code_o,
  output logic              ilv_o,
  output logic [LAT_W-1:0]  lat_o,
  output logic              wr_single_o,
  output logic              legal_o,
  output logic              reject_o
);

  mode_word_t mode_q;
  logic       legal_q;
  logic       reject_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RESET;
      legal_q  <= 1'b1;
      reject_q <= 1'b0;
    end else begin
      reject_q <= load_i & active_i;
      if (load_i && !active_i) begin
        mode_q  <= mode_word_t'(word_i);
        legal_q <= mode_legal(mode_word_t'(word_i));
      end
    end
  end

  assign bl_code_o   = mode_q.bl[1:0];
  assign ilv_o       = mode_q.ilv;
  assign lat_o       = (mode_q.lat == 3'd3) ? LAT_W'(3) : LAT_W'(2);
  assign wr_single_o = mode_q.wr_single;
  assign legal_o     = legal_q;
  assign reject_o    = reject_q;

  // R10: a load during an unfinished burst leaves the mode untouched and is reported
  assert_load_dropped_R10: assert property (@(posedge clk) disable iff (rst)
    (load_i && active_i) |=> ($stable(mode_q) && $stable(legal_q) && reject_q));

endmodule

// File: rtl/sdr_beat_gen.sv
module sdr_beat_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  output logic             iss_v_o,
  output logic             iss_wr_o,
  output logic [COL_W-1:0] iss_col_o,
  output logic             busy_o
);

  localparam int IDX_W = 3;

  logic [COL_W-1:0] st_col_q;
  logic [1:0]       code_q;
  logic             ilv_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             iss_v_q;
  logic             iss_wr_q;
  logic [COL_W-1:0] iss_col_q;
  logic [1:0]       eff_code;
  logic [IDX_W-1:0] last_idx;

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] base,
    input logic [1:0]       code,
    input logic             ilv,
    input logic [IDX_W-1:0] i
  );
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low;
    mask = COL_W'(4'((4'd1 << code) - 4'd1));
    low  = ilv ? (base ^ COL_W'(i)) : (base + COL_W'(i));
    return (base & ~mask) | (low & mask);
  endfunction

  assign eff_code = (start_wr_i && wr_single_i) ? 2'd0 : bl_code_i;
  assign last_idx = IDX_W'((4'd1 << code_q) - 4'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_col_q  <= '0;
      code_q    <= '0;
      ilv_q     <= 1'b0;
      idx_q     <= '0;
      busy_q    <= 1'b0;
      iss_v_q   <= 1'b0;
      iss_wr_q  <= 1'b0;
      iss_col_q <= '0;
    end else if (start_i) begin
      st_col_q  <= start_col_i;
      code_q    <= eff_code;
      ilv_q     <= ilv_i;
      idx_q     <= IDX_W'(1);
      busy_q    <= (eff_code != 2'd0);
      iss_v_q   <= 1'b1;
      iss_wr_q  <= start_wr_i;
      iss_col_q <= start_col_i;
    end else if (busy_q) begin
      iss_v_q   <= 1'b1;
      iss_col_q <= beat_col(st_col_q, code_q, ilv_q, idx_q);
      idx_q     <= idx_q + IDX_W'(1);
      busy_q    <= (idx_q != last_idx);
    end else begin
      iss_v_q   <= 1'b0;
    end
  end

  assign iss_v_o   = iss_v_q;
  assign iss_wr_o  = iss_wr_q;
  assign iss_col_o = iss_col_q;
  assign busy_o    = busy_q;

  // R2: beats follow on consecutive clocks while some remain
  assert_beats_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !start_i) |=> iss_v_q);

  // R3 / R4: every continuing beat stays inside the length-aligned block of its start
  assert_beat_in_block_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !start_i) |=> ((iss_col_q >> code_q) == (st_col_q >> code_q)));

  // R8: single-location write mode issues exactly one beat
  assert_single_write_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && start_wr_i && wr_single_i) |=> (iss_v_q && iss_wr_q && !busy_q));

endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_v_i,
  input  logic [COL_W-1:0] beat_col_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             inflight_o,
  output logic             rd_valid_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic             oe_o
);

  logic             v_q   [MAX_LAT];
  logic [COL_W-1:0] col_q [MAX_LAT];
  logic             rv_q;
  logic [COL_W-1:0] rcol_q;
  logic             oe_q;
  logic             inflight;
  logic [LAT_W-1:0] sel_data;
  logic [LAT_W-1:0] sel_lead;

  assign v_q[0]   = beat_v_i;
  assign col_q[0] = beat_col_i;

  for (genvar k = 1; k < MAX_LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[k]   <= 1'b0;
        col_q[k] <= '0;
      end else begin
        v_q[k]   <= v_q[k-1];
        col_q[k] <= col_q[k-1];
      end
    end
  end

  assign sel_data = lat_i - LAT_W'(1);
  assign sel_lead = lat_i - LAT_W'(2);

  always_comb begin
    inflight = 1'b0;
    for (int k = 1; k < MAX_LAT; k++) begin
      if (k < int'(lat_i)) inflight = inflight | v_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q   <= 1'b0;
      rcol_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      rv_q   <= v_q[sel_data];
      rcol_q <= col_q[sel_data];
      oe_q   <= v_q[sel_data] | v_q[sel_lead];
    end
  end

  assign inflight_o = inflight;
  assign rd_valid_o = rv_q;
  assign rd_col_o   = rcol_q;
  assign oe_o       = oe_q;

  // R6: drive is on whenever a beat is valid
  assert_drive_with_data_R6: assert property (@(posedge clk) disable iff (rst)
    rv_q |-> oe_q);

  // R6: drive was already on in the cycle before any valid beat
  assert_drive_leads_R6: assert property (@(posedge clk) disable iff (rst)
    rv_q |-> $past(oe_q));

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_burst_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_valid_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic              dq_oe_o,
  output logic              wr_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mode_err_o,
  output logic              load_rej_o
);

  sdr_cmd_e         cmd;
  logic             start;
  logic             active;
  logic [1:0]       bl_code;
  logic             ilv;
  logic [LAT_W-1:0] lat;
  logic             wr_single;
  logic             legal;
  logic             iss_v;
  logic             iss_wr;
  logic [COL_W-1:0] iss_col;
  logic             busy;
  logic             rd_inflight;
  logic [DATA_W-1:0] wdata_q;

  assign cmd    = sdr_cmd_e'(cmd_i);
  assign start  = legal && ((cmd == CMD_READ) || (cmd == CMD_WRITE));
  assign active = busy | iss_v | rd_inflight;

  sdr_mode_reg i_mode (
    .clk         (clk),
    .rst         (rst),
    .load_i      (cmd == CMD_LOAD),
    .word_i      (addr_i[MODE_W-1:0]),
    .active_i    (active),
    .bl_code_o   (bl_code),
    .ilv_o       (ilv),
    .lat_o       (lat),
    .wr_single_o (wr_single),
    .legal_o     (legal),
    .reject_o    (load_rej_o)
  );

  sdr_beat_gen #(.COL_W(COL_W)) i_beats (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .start_wr_i  (cmd == CMD_WRITE),
    .start_col_i (addr_i[COL_W-1:0]),
    .bl_code_i   (bl_code),
    .ilv_i       (ilv),
    .wr_single_i (wr_single),
    .iss_v_o     (iss_v),
    .iss_wr_o    (iss_wr),
    .iss_col_o   (iss_col),
    .busy_o      (busy)
  );

  sdr_read_pipe #(.COL_W(COL_W)) i_rd_pipe (
    .clk        (clk),
    .rst        (rst),
    .beat_v_i   (iss_v & ~iss_wr),
    .beat_col_i (iss_col),
    .lat_i      (lat),
    .inflight_o (rd_inflight),
    .rd_valid_o (rd_valid_o),
    .rd_col_o   (rd_col_o),
    .oe_o       (dq_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) wdata_q <= '0;
    else     wdata_q <= wdata_i;
  end

  assign wr_o       = iss_v & iss_wr;
  assign wr_col_o   = iss_col;
  assign wr_data_o  = wdata_q;
  assign mode_err_o = ~legal;

  // R9: no access of either kind is ever seen under an illegal mode word
  assert_no_access_on_bad_mode_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_o || rd_valid_o) |-> !mode_err_o);

endmodule

// File: tb/test_sdr_burst_ctrl.sv
`timescale 1ns/1ps
module test_sdr_burst_ctrl;

  localparam int ADDR_W = 10;
  localparam int COL_W  = 9;
  localparam int DATA_W = 16;
  localparam logic [1:0] C_NOP = 2'b00, C_LOAD = 2'b01, C_READ = 2'b10, C_WRITE = 2'b11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cmd = C_NOP;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              rd_valid, dq_oe, wr, mode_err, load_rej;
  logic [COL_W-1:0]  rd_col, wr_col;
  logic [DATA_W-1:0] wr_data;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdr_burst_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_sdr_burst_ctrl (
    .clk(clk), .rst(rst), .cmd_i(cmd), .addr_i(addr), .wdata_i(wdata),
    .rd_valid_o(rd_valid), .rd_col_o(rd_col), .dq_oe_o(dq_oe),
    .wr_o(wr), .wr_col_o(wr_col), .wr_data_o(wr_data),
    .mode_err_o(mode_err), .load_rej_o(load_rej)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(int start, int code, bit ilv, int i);
    int len  = 1 << code;
    int off  = start % len;
    int base = start - off;
    if (ilv) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  function automatic logic [ADDR_W-1:0] mword(int bl, bit ilv, int cl, bit ws, int op);
    return ADDR_W'((int'(ws) << 9) | (op << 7) | (cl << 4) | (int'(ilv) << 3) | bl);
  endfunction

  function automatic logic [DATA_W-1:0] pat(int s, int t);
    return DATA_W'(32'h5000 + s * 16 + t);
  endfunction

  task automatic load_word(input logic [ADDR_W-1:0] w);
    cmd = C_LOAD; addr = w; step();
    cmd = C_NOP; addr = '0; step();
  endtask

  task automatic run_read(int start, int code, bit ilv, int cl, string tv, string to, string tc);
    int len = 1 << code;
    cmd = C_READ; addr = ADDR_W'(start); step();
    cmd = C_NOP;
    for (int t = 1; t <= cl + len; t++) begin
      bit ev;
      bit eo;
      step();
      ev = (t >= cl) && (t < cl + len);
      eo = (t >= cl - 1) && (t < cl + len);
      check(rd_valid == ev, tv, rd_valid, ev);
      check(dq_oe == eo, to, dq_oe, eo);
      if (ev) check(int'(rd_col) == exp_col(start, code, ilv, t - cl), tc, rd_col,
                    exp_col(start, code, ilv, t - cl));
    end
  endtask

  task automatic run_write(int start, int code, bit ilv, bit ws, string tw, string tc);
    int lw = ws ? 1 : (1 << code);
    for (int t = 0; t <= lw; t++) begin
      bit ew;
      cmd   = (t == 0) ? C_WRITE : C_NOP;
      addr  = ADDR_W'(start);
      wdata = pat(start, t);
      step();
      ew = (t < lw);
      check(wr == ew, tw, wr, ew);
      if (ew) begin
        check(int'(wr_col) == exp_col(start, code, ilv, t), tc, wr_col, exp_col(start, code, ilv, t));
        check(wr_data == pat(start, t), tw, wr_data, pat(start, t));
      end
    end
    cmd = C_NOP;
  endtask

  // second command of the same kind at edge tb; sequential order
  task automatic run_pair(bit is_wr, int a, int b, int code, int tb, int cl);
    int len   = 1 << code;
    int lat   = is_wr ? 0 : cl;
    int total = tb + len;
    for (int t = 0; t <= lat + total; t++) begin
      int k;
      int ec;
      bit ev;
      bit eo;
      cmd   = (t == 0 || t == tb) ? (is_wr ? C_WRITE : C_READ) : C_NOP;
      addr  = ADDR_W'((t == 0) ? a : b);
      wdata = pat(a, t);
      step();
      k  = t - lat;
      ev = (k >= 0) && (k < total);
      eo = (k >= -1) && (k < total);
      ec = (k < tb) ? exp_col(a, code, 1'b0, k) : exp_col(b, code, 1'b0, k - tb);
      if (is_wr) begin
        check(wr == ev, "R7", wr, ev);
        if (ev) begin
          check(int'(wr_col) == ec, "R7", wr_col, ec);
          check(wr_data == pat(a, t), "R7", wr_data, pat(a, t));
        end
      end else begin
        check(rd_valid == ev, "R7", rd_valid, ev);
        check(dq_oe == eo, "R7", dq_oe, eo);
        if (ev) check(int'(rd_col) == ec, "R7", rd_col, ec);
      end
    end
    cmd = C_NOP;
  endtask

  task automatic load_during(bit is_wr, int lt, bit rej, logic [ADDR_W-1:0] w);
    cmd = is_wr ? C_WRITE : C_READ; addr = ADDR_W'(4); step();
    for (int t = 1; t <= lt + 1; t++) begin
      cmd  = (t == lt) ? C_LOAD : C_NOP;
      addr = (t == lt) ? w : ADDR_W'(4);
      step();
      check(load_rej == (rej && t == lt), "R10", load_rej, rej && t == lt);
    end
    cmd = C_NOP;
    step();
    step();
  endtask

  function automatic logic [ADDR_W-1:0] bad_word(int j);
    case (j)
      0: return mword(0, 0, 2, 0, 1);
      1: return mword(1, 0, 2, 0, 2);
      2: return mword(2, 1, 3, 0, 3);
      3: return mword(0, 0, 0, 0, 0);
      4: return mword(1, 0, 1, 0, 0);
      5: return mword(2, 0, 4, 0, 0);
      6: return mword(0, 0, 7, 1, 0);
      7: return mword(4, 0, 2, 0, 0);
      default: return mword(7, 1, 3, 0, 0);
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R1: reset state at the ports
    check(rd_valid == 1'b0, "R1", rd_valid, 0);
    check(dq_oe == 1'b0, "R1", dq_oe, 0);
    check(wr == 1'b0, "R1", wr, 0);
    check(mode_err == 1'b0, "R1", mode_err, 0);
    check(load_rej == 1'b0, "R1", load_rej, 0);
    // R1: default mode without any load
    run_read(51, 0, 1'b0, 2, "R1", "R1", "R1");
    run_write(77, 0, 1'b0, 1'b0, "R1", "R1");

    // R2 R3 R4 R5 R6 R8 sweep over every legal mode and all low start offsets
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int cl = 2; cl < 4; cl++)
          for (int ws = 0; ws < 2; ws++) begin
            load_word(mword(code, il[0], cl, ws[0], 0));
            for (int s = 0; s < 8; s++) begin
              int start = (s * 73) % 512;
              run_read(start, code, il[0], cl, "R5", "R6", il[0] ? "R4" : "R3");
              run_write(start, code, il[0], ws[0], "R8", (il[0] ? "R4" : "R2"));
            end
          end

    // R7: seamless and truncating command pairs
    for (int cl = 2; cl < 4; cl++) begin
      load_word(mword(2, 0, cl, 0, 0));
      run_pair(1'b0, 5, 10, 2, 4, cl);
      load_word(mword(3, 0, cl, 0, 0));
      run_pair(1'b0, 3, 20, 3, 2, cl);
    end
    load_word(mword(2, 0, 2, 0, 0));
    run_pair(1'b1, 6, 13, 2, 1, 2);
    run_pair(1'b1, 9, 30, 2, 4, 2);

    // R9: reserved mode words
    for (int j = 0; j < 9; j++) begin
      load_word(bad_word(j));
      check(mode_err == 1'b1, "R9", mode_err, 1);
      cmd = C_READ; addr = '0; step();
      cmd = C_NOP;
      for (int t = 0; t < 6; t++) begin
        check(rd_valid == 1'b0, "R9", rd_valid, 0);
        check(dq_oe == 1'b0, "R9", dq_oe, 0);
        step();
      end
      cmd = C_WRITE; step();
      cmd = C_NOP;
      check(wr == 1'b0, "R9", wr, 0);
      step();
      check(wr == 1'b0, "R9", wr, 0);
    end
    load_word(mword(1, 0, 2, 0, 0));
    check(mode_err == 1'b0, "R9", mode_err, 0);

    // R10: load-window edges (mode is BL2, latency 2)
    load_during(1'b0, 3, 1'b1, mword(3, 0, 3, 0, 0));
    run_read(9, 1, 1'b0, 2, "R10", "R10", "R10");
    load_during(1'b0, 4, 1'b0, mword(3, 0, 3, 0, 0));
    run_read(9, 3, 1'b0, 3, "R10", "R10", "R10");
    load_during(1'b1, 8, 1'b1, mword(1, 0, 2, 0, 0));
    run_write(12, 3, 1'b0, 1'b0, "R10", "R10");
    load_during(1'b1, 9, 1'b0, mword(1, 0, 2, 0, 0));
    run_read(12, 1, 1'b0, 2, "R10", "R10", "R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule